// File: doc/BRIEF.md
# Segmented Two-Level Page-Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address for a memory system built on 512-byte pages. The top two address bits pick one of four regions: user code/data (`00`), user stack (`01`), system (`10`) and an unused region (`11`). A system address is translated with a single page-table-entry (PTE) read from a table whose physical base is held in a base input. A user address first forms the virtual address of its own PTE from a per-region base, and that PTE address lives in system space. So it must itself be translated through the system table before the user PTE can be fetched.

The walker accepts one request at a time. It drives at most one memory read at a time on a simple request/response port and ends each walk with either a physical address or a fault report. The report says which stage failed and gives the virtual address whose translation failed. TLBs, protection checks and fault handling belong to the surrounding logic.

Top module: `segwalk_top`

## Requirements
- R1: A request whose bits 31..30 are `11` ends with `fault_kind` = 3 (access fault) and `fault_va` equal to the request address, without any memory read.
- R2: A request in region `10` makes exactly one read, at `sys_tbl_base + VPN*4`, where VPN is bits 29..9. If bit 31 of the returned PTE is 1, the result is `{PTE[20:0], VA[8:0]}`.
- R3: A request in region `00` forms its PTE virtual address as `code_tbl_base + VPN*4`, and one in region `01` uses `stack_tbl_base + VPN*4`, both computed modulo 2^32. If bits 31..30 of that PTE address are not `10`, the walk ends with `fault_kind` = 3, `fault_va` equal to the request address, and no read.
- R4: A user walk reads first at `sys_tbl_base + PTEVA[29:9]*4`. It then reads at `{PTE1[20:0], PTEVA[8:0]}`, and the result is `{PTE2[20:0], VA[8:0]}`. That makes exactly two reads.
- R5: If bit 31 of the PTE from the first read is 0, the walk ends with `fault_kind` = 1. `fault_va` is then the request address for a system walk, or the PTE virtual address for a user walk.
- R6: If bit 31 of the PTE from the second read of a user walk is 0, the walk ends with `fault_kind` = 2 and `fault_va` equal to the request address.
- R7: Each walk ends with `done_valid` or `fault_valid` high for exactly one cycle, never both at once. `fault_kind` is 0 whenever `fault_valid` is low, and `req_ready` is high again in the following cycle.
- R8: After reset, `req_ready` is high and `done_valid`, `fault_valid` and `mem_rd_valid` are low. No read is issued while `req_ready` is high.
- R9: A read request holds `mem_rd_valid` high with a stable `mem_rd_addr` until the cycle in which `mem_rsp_valid` returns its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a walk; taken when `req_ready` is high |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Walker idle |
| sys_tbl_base | input | 30 | Physical base of the system page table |
| code_tbl_base | input | 32 | System-space virtual base of the user code/data page table |
| stack_tbl_base | input | 32 | System-space virtual base of the user stack page table |
| mem_rd_valid | output | 1 | PTE read request, held until the response |
| mem_rd_addr | output | 30 | Physical address of the PTE |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | PTE: bit 31 valid, bits 20..0 frame number |
| done_valid | output | 1 | Translation finished without fault |
| done_pa | output | 30 | Physical address result |
| fault_valid | output | 1 | Walk ended in a fault |
| fault_kind | output | 2 | 1 system-table stage, 2 user-PTE stage, 3 access |
| fault_va | output | 32 | Virtual address whose translation failed |

## Verification
The bench builds the walker with its default widths: a 32-bit virtual address, a 30-bit physical address and a 9-bit page offset. These match the memory model, whose PTE validity follows physical address bit 29 and whose frame top bit copies bit 28. With table bases placed in those bands, every fault stage, the all-ones VPN and a user PTE address that wraps out of system space can all be reached. The same vector set also shows whether the frame top bit reaches the output unclipped.

// File: rtl/segwalk_pkg.sv
package segwalk_pkg;

   typedef enum logic [1:0] {
      RGN_USER_CODE  = 2'b00,
      RGN_USER_STACK = 2'b01,
      RGN_SYSTEM     = 2'b10,
      RGN_UNUSED     = 2'b11
   } region_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SYS_READ,
      ST_USER_PTE_READ,
      ST_DONE
   } walk_state_e;

   localparam logic [1:0] FLT_NONE   = 2'd0;
   localparam logic [1:0] FLT_SYSTBL = 2'd1;
   localparam logic [1:0] FLT_USRPTE = 2'd2;
   localparam logic [1:0] FLT_ACCESS = 2'd3;

   localparam int PTE_BYTES_LOG2 = 2;

endpackage

// File: rtl/segwalk_decode.sv
module segwalk_decode
   import segwalk_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 30,
   parameter int OFFS_W = 9
) (
   input  logic [VA_W-1:0] va,
   input  logic [VA_W-1:0] code_base,
   input  logic [VA_W-1:0] stack_base,
   input  logic [PA_W-1:0] sys_base,
   output logic            is_user,
   output logic            access_err,
   output logic [VA_W-1:0] pte_va,
   output logic [PA_W-1:0] stage1_addr
);
   localparam int VPN_W = VA_W - 2 - OFFS_W;

   region_e           region;
   region_e           pte_region;
   logic [VPN_W-1:0]  vpn;
   logic [VPN_W-1:0]  target_vpn;
   logic [VA_W-1:0]   user_base;
   logic              unused_offset;

   assign region        = region_e'(va[VA_W-1 -: 2]);
   assign vpn           = va[VA_W-3:OFFS_W];
   assign unused_offset = ^va[OFFS_W-1:0];

   assign is_user    = (region == RGN_USER_CODE) || (region == RGN_USER_STACK);
   assign user_base  = (region == RGN_USER_STACK) ? stack_base : code_base;
   assign pte_va     = user_base + VA_W'({vpn, {PTE_BYTES_LOG2{1'b0}}});
   assign pte_region = region_e'(pte_va[VA_W-1 -: 2]);

   assign target_vpn  = is_user ? pte_va[VA_W-3:OFFS_W] : vpn;
   assign stage1_addr = sys_base + PA_W'({target_vpn, {PTE_BYTES_LOG2{1'b0}}});

   assign access_err = (region == RGN_UNUSED) ||
                       (is_user && (pte_region != RGN_SYSTEM));

endmodule

// File: rtl/segwalk_fsm.sv
module segwalk_fsm
   import segwalk_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 30,
   parameter int OFFS_W = 9,
   parameter int PTE_W  = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   input  logic [VA_W-1:0] req_va,
   input  logic            is_user,
   input  logic            access_err,
   input  logic [VA_W-1:0] pte_va,
   input  logic [PA_W-1:0] stage1_addr,
   output logic            req_ready,
   output logic            mem_rd_valid,
   output logic [PA_W-1:0] mem_rd_addr,
   input  logic            mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic            done_valid,
   output logic [PA_W-1:0] done_pa,
   output logic            fault_valid,
   output logic [1:0]      fault_kind,
   output logic [VA_W-1:0] fault_va
);
   localparam int PFN_W     = PA_W - OFFS_W;
   localparam int VALID_BIT = PTE_W - 1;

   walk_state_e       state;
   logic [VA_W-1:0]   va_q;
   logic [VA_W-1:0]   pte_va_q;
   logic              user_q;
   logic [PA_W-1:0]   rd_addr_q;
   logic [PA_W-1:0]   pa_q;
   logic [1:0]        kind_q;
   logic [VA_W-1:0]   fva_q;
   logic              pte_ok;
   logic [PFN_W-1:0]  pte_pfn;
   logic              unused_pte_bits;

   assign pte_ok          = mem_rsp_data[VALID_BIT];
   assign pte_pfn         = mem_rsp_data[PFN_W-1:0];
   assign unused_pte_bits = ^mem_rsp_data[VALID_BIT-1:PFN_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         va_q      <= '0;
         pte_va_q  <= '0;
         user_q    <= 1'b0;
         rd_addr_q <= '0;
         pa_q      <= '0;
         kind_q    <= FLT_NONE;
         fva_q     <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q     <= req_va;
                  pte_va_q <= pte_va;
                  user_q   <= is_user;
                  if (access_err) begin
                     kind_q <= FLT_ACCESS;
                     fva_q  <= req_va;
                     state  <= ST_DONE;
                  end else begin
                     kind_q    <= FLT_NONE;
                     rd_addr_q <= stage1_addr;
                     state     <= ST_SYS_READ;
                  end
               end
            end
            ST_SYS_READ: begin
               if (mem_rsp_valid) begin
                  if (!pte_ok) begin
                     kind_q <= FLT_SYSTBL;
                     fva_q  <= user_q ? pte_va_q : va_q;
                     state  <= ST_DONE;
                  end else if (user_q) begin
                     rd_addr_q <= {pte_pfn, pte_va_q[OFFS_W-1:0]};
                     state     <= ST_USER_PTE_READ;
                  end else begin
                     pa_q  <= {pte_pfn, va_q[OFFS_W-1:0]};
                     state <= ST_DONE;
                  end
               end
            end
            ST_USER_PTE_READ: begin
               if (mem_rsp_valid) begin
                  if (!pte_ok) begin
                     kind_q <= FLT_USRPTE;
                     fva_q  <= va_q;
                  end else begin
                     pa_q <= {pte_pfn, va_q[OFFS_W-1:0]};
                  end
                  state <= ST_DONE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state == ST_IDLE);
   assign mem_rd_valid = (state == ST_SYS_READ) || (state == ST_USER_PTE_READ);
   assign mem_rd_addr  = rd_addr_q;
   assign done_valid   = (state == ST_DONE) && (kind_q == FLT_NONE);
   assign fault_valid  = (state == ST_DONE) && (kind_q != FLT_NONE);
   assign fault_kind   = fault_valid ? kind_q : FLT_NONE;
   assign done_pa      = pa_q;
   assign fault_va     = fva_q;

   assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_valid && fault_valid));

   assert_outcome_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid || fault_valid) |=> (!done_valid && !fault_valid && req_ready));

   assert_idle_no_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_rd_valid);

   assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rsp_valid) |=> (mem_rd_valid && $stable(mem_rd_addr)));

   assert_user_fault_stage_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && fault_kind == FLT_USRPTE) |-> $past(state == ST_USER_PTE_READ));

   assert_sys_read_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_USER_PTE_READ) |-> $past(state == ST_SYS_READ && mem_rsp_valid));

endmodule

// File: rtl/segwalk_top.sv
module segwalk_top
   import segwalk_pkg::*;
#(
   parameter int VA_W   = 32,
   parameter int PA_W   = 30,
   parameter int OFFS_W = 9,
   parameter int PTE_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_va,
   output logic             req_ready,
   input  logic [PA_W-1:0]  sys_tbl_base,
   input  logic [VA_W-1:0]  code_tbl_base,
   input  logic [VA_W-1:0]  stack_tbl_base,
   output logic             mem_rd_valid,
   output logic [PA_W-1:0]  mem_rd_addr,
   input  logic             mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic             done_valid,
   output logic [PA_W-1:0]  done_pa,
   output logic             fault_valid,
   output logic [1:0]       fault_kind,
   output logic [VA_W-1:0]  fault_va
);
   localparam int VPN_W = VA_W - 2 - OFFS_W;
   localparam int PFN_W = PA_W - OFFS_W;

   generate
      if (VPN_W < 1) begin : g_bad_vpn
         $error("segwalk_top: virtual address too narrow for region and offset fields");
      end
      if (PFN_W < 1 || PFN_W + 1 > PTE_W) begin : g_bad_pfn
         $error("segwalk_top: frame number does not fit below the PTE valid bit");
      end
      if (OFFS_W < PTE_BYTES_LOG2) begin : g_bad_offs
         $error("segwalk_top: page offset narrower than a PTE");
      end
   endgenerate

   logic            is_user;
   logic            access_err;
   logic [VA_W-1:0] pte_va;
   logic [PA_W-1:0] stage1_addr;

   segwalk_decode #(.VA_W(VA_W), .PA_W(PA_W), .OFFS_W(OFFS_W)) i_decode (
      .va          (req_va),
      .code_base   (code_tbl_base),
      .stack_base  (stack_tbl_base),
      .sys_base    (sys_tbl_base),
      .is_user     (is_user),
      .access_err  (access_err),
      .pte_va      (pte_va),
      .stage1_addr (stage1_addr)
   );

   segwalk_fsm #(.VA_W(VA_W), .PA_W(PA_W), .OFFS_W(OFFS_W), .PTE_W(PTE_W)) i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_va       (req_va),
      .is_user      (is_user),
      .access_err   (access_err),
      .pte_va       (pte_va),
      .stage1_addr  (stage1_addr),
      .req_ready    (req_ready),
      .mem_rd_valid (mem_rd_valid),
      .mem_rd_addr  (mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data (mem_rsp_data),
      .done_valid   (done_valid),
      .done_pa      (done_pa),
      .fault_valid  (fault_valid),
      .fault_kind   (fault_kind),
      .fault_va     (fault_va)
   );

   assert_unused_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && req_va[VA_W-1 -: 2] == 2'b11)
      |=> (fault_valid && fault_kind == FLT_ACCESS && !mem_rd_valid));

   assert_sys_single_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid && req_va[VA_W-1 -: 2] == 2'b10)
      |=> (mem_rd_valid && mem_rd_addr == $past(sys_tbl_base + PA_W'({req_va[VA_W-3:OFFS_W], 2'b00}))));

endmodule

// File: tb/test_segwalk_top.sv
`timescale 1ns/1ps
module test_segwalk_top;

   typedef struct packed {
      logic [31:0] va;
      logic [29:0] sbase;
      logic [31:0] cbase;
      logic [31:0] kbase;
      logic [1:0]  kind;
   } vec_t;

   localparam logic [29:0] SB  = 30'h0010_0000;
   localparam logic [31:0] CB  = 32'h8000_4000;
   localparam logic [31:0] KB  = 32'h8002_0000;
   localparam int NVEC = 11;

   localparam vec_t VECS [NVEC] = '{
      '{32'h8000_0A05, SB,            CB,            KB,            2'd0},
      '{32'h0000_1234, SB,            CB,            KB,            2'd0},
      '{32'h4000_0400, SB,            CB,            KB,            2'd0},
      '{32'hC000_0000, SB,            CB,            KB,            2'd3},
      '{32'h0000_0200, SB,            32'h0000_1000, KB,            2'd3},
      '{32'h8000_0000, 30'h2000_0000, CB,            KB,            2'd1},
      '{32'h0000_0600, 30'h2000_0000, CB,            KB,            2'd1},
      '{32'h0000_0800, 30'h1000_0000, CB,            KB,            2'd2},
      '{32'h8000_1FFF, 30'h1000_0000, CB,            KB,            2'd0},
      '{32'h4000_0A00, SB,            CB,            32'hBFFF_FFF0, 2'd3},
      '{32'h7FFF_FFFF, SB,            CB,            KB,            2'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_va = '0;
   logic        req_ready;
   logic [29:0] sys_tbl_base = '0;
   logic [31:0] code_tbl_base = '0;
   logic [31:0] stack_tbl_base = '0;
   logic        mem_rd_valid;
   logic [29:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        done_valid;
   logic [29:0] done_pa;
   logic        fault_valid;
   logic [1:0]  fault_kind;
   logic [31:0] fault_va;

   int checks = 0;
   int fails = 0;
   int nreads = 0;
   int hold_err = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   segwalk_top i_segwalk_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_ready(req_ready), .sys_tbl_base(sys_tbl_base),
      .code_tbl_base(code_tbl_base), .stack_tbl_base(stack_tbl_base),
      .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done_valid(done_valid), .done_pa(done_pa), .fault_valid(fault_valid),
      .fault_kind(fault_kind), .fault_va(fault_va)
   );

   // Memory model: PTE valid unless physical bit 29 is set; frame top bit copies bit 28.
   function automatic logic [31:0] pte_at(input logic [29:0] a);
      return {~a[29], 10'h0, a[28], a[21:2]};
   endfunction

   logic        busy = 1'b0;
   int          lat = 0;
   logic [29:0] addr_q = '0;

   always @(negedge clk) begin
      if (mem_rsp_valid) begin
         mem_rsp_valid <= 1'b0;
      end else if (busy) begin
         if (lat == 0) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= pte_at(addr_q);
            busy          <= 1'b0;
            nreads        <= nreads + 1;
            if (!mem_rd_valid || mem_rd_addr != addr_q) hold_err <= hold_err + 1;
         end else begin
            lat <= lat - 1;
         end
      end else if (mem_rd_valid) begin
         busy   <= 1'b1;
         addr_q <= mem_rd_addr;
         lat    <= 1;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Reference walk written from the requirements.
   task automatic ref_walk(input vec_t v, output logic [1:0] k, output logic [29:0] pa,
                           output logic [31:0] fva, output int nrd);
      logic [20:0] vpn;
      logic [31:0] pv;
      logic [31:0] p1;
      logic [31:0] p2;
      logic [29:0] a1;
      vpn = v.va[29:9];
      k = 2'd0; pa = '0; fva = '0; nrd = 0;
      if (v.va[31:30] == 2'b11) begin
         k = 2'd3; fva = v.va;
      end else if (v.va[31:30] == 2'b10) begin
         a1 = v.sbase + {7'd0, vpn, 2'b00};
         p1 = pte_at(a1); nrd = 1;
         if (!p1[31]) begin k = 2'd1; fva = v.va; end
         else pa = {p1[20:0], v.va[8:0]};
      end else begin
         pv = ((v.va[31:30] == 2'b00) ? v.cbase : v.kbase) + {9'd0, vpn, 2'b00};
         if (pv[31:30] != 2'b10) begin
            k = 2'd3; fva = v.va;
         end else begin
            a1 = v.sbase + {7'd0, pv[29:9], 2'b00};
            p1 = pte_at(a1); nrd = 1;
            if (!p1[31]) begin
               k = 2'd1; fva = pv;
            end else begin
               p2 = pte_at({p1[20:0], pv[8:0]}); nrd = 2;
               if (!p2[31]) begin k = 2'd2; fva = v.va; end
               else pa = {p2[20:0], v.va[8:0]};
            end
         end
      end
   endtask

   initial begin
      int wd;
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1, "R8", "req_ready after reset", {31'd0, req_ready}, 32'd1);
      check(!done_valid && !fault_valid, "R8", "outputs after reset",
            {30'd0, done_valid, fault_valid}, 32'd0);
      check(mem_rd_valid == 1'b0, "R8", "no read after reset", {31'd0, mem_rd_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         logic [1:0]  ek;
         logic [29:0] epa;
         logic [31:0] efva;
         int          enrd;
         int          n0;
         ref_walk(VECS[i], ek, epa, efva, enrd);
         check(ek == VECS[i].kind, "R3", $sformatf("vec %0d table outcome", i),
               {30'd0, ek}, {30'd0, VECS[i].kind});
         n0 = nreads;
         sys_tbl_base   = VECS[i].sbase;
         code_tbl_base  = VECS[i].cbase;
         stack_tbl_base = VECS[i].kbase;
         req_va         = VECS[i].va;
         req_valid      = 1'b1;
         @(negedge clk);
         req_valid = 1'b0;
         wd = 0;
         while (!done_valid && !fault_valid && wd < 1000) begin
            @(negedge clk);
            wd++;
         end
         if (wd >= 1000) begin
            check(1'b0, "R7", $sformatf("vec %0d watchdog", i), 32'd0, 32'd1);
         end else begin
            check(!(done_valid && fault_valid), "R7", $sformatf("vec %0d exclusive", i),
                  {30'd0, done_valid, fault_valid}, 32'd1);
            if (ek == 2'd0) begin
               check(done_valid && done_pa == epa, (enrd == 1) ? "R2" : "R4",
                     $sformatf("vec %0d physical address", i), {2'd0, done_pa}, {2'd0, epa});
            end else begin
               check(fault_valid && fault_kind == ek,
                     (ek == 2'd3) ? "R1" : (ek == 2'd1) ? "R5" : "R6",
                     $sformatf("vec %0d fault kind", i), {30'd0, fault_kind}, {30'd0, ek});
               check(fault_va == efva, (ek == 2'd2) ? "R6" : "R5",
                     $sformatf("vec %0d fault va", i), fault_va, efva);
            end
            check(nreads - n0 == enrd, (ek == 2'd3) ? "R3" : "R4",
                  $sformatf("vec %0d read count", i), nreads - n0, enrd);
            @(negedge clk);
            check(!done_valid && !fault_valid && req_ready && fault_kind == 2'd0, "R7",
                  $sformatf("vec %0d one-cycle outcome", i),
                  {29'd0, done_valid, fault_valid, req_ready}, 32'd1);
         end
      end

      check(hold_err == 0, "R9", "read address held until response", hold_err, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL R7 global watchdog: actual %0d expected %0d", cycles, 150000);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule